// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block translates a virtual page number into a physical frame in a single combinational lookup. Every resident entry is compared at once against the requested page number and the requesting address-space number. The translated physical address is the stored frame bits placed above the untranslated page offset. The protection bits of the chosen entry are returned with it. Each entry carries its own address-space number, so translations that belong to different contexts can stay resident together, and a context switch does not have to empty the buffer.

Software-style fills arrive on a write port and land in the slot named by a round-robin pointer. Two invalidate controls are provided. One drops every translation. The other drops only the translations of one address-space number. A lookup never changes the stored state, and entries track no use or reference history.

Each cycle the write side decodes its controls into one named operation, in priority order: FLUSH_ALL (invalidate-all asserted), FILL_FLUSH_ASN (fill together with an address-space flush), FILL, FLUSH_ASN, and IDLE (no write). The entry array moves from its current contents to the next contents according to that operation.

Top module: `asn_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports `miss`=1 and `hit`=0, and the fill pointer rests at slot 0.
- R2: `hit` is 1 exactly when some valid entry has a tag equal to `lk_vpn` and an address-space number equal to `lk_asn`, and `miss` is always the inverse of `hit`.
- R3: On a hit, `pa` equals the entry's 31-bit frame field in bits 43..13 joined with `lk_off` in bits 12..0, and `prot` equals the entry's 4 protection bits.
- R4: Entries with the same page number and different address-space numbers coexist, and each lookup returns only the entry of its own address-space number.
- R5: A fill writes tag, address-space number, frame and protection into the slot at the fill pointer and marks it valid on the next edge. The pointer then advances by one and wraps from ENTRIES-1 to 0, so fill ENTRIES+1 replaces the first-filled slot.
- R6: When several valid entries match a lookup, the entry with the lowest index supplies `pa` and `prot`.
- R7: `inv_all` clears every valid bit in one cycle. A fill in the same cycle is dropped, and the pointer does not advance.
- R8: `inv_asn_en` clears only the valid entries whose address-space number equals `inv_asn`. A fill in the same cycle still writes its slot valid, even when its own address-space number equals `inv_asn`.
- R9: Lookups on their own never change the stored entries or the fill pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vpn | input | 35 | Lookup virtual page number |
| lk_off | input | 13 | Lookup page offset, passed through |
| lk_asn | input | 8 | Lookup address-space number |
| hit | output | 1 | A valid entry matches |
| miss | output | 1 | No valid entry matches |
| pa | output | 44 | Physical address {frame, offset}; don't-care on miss |
| prot | output | 4 | Protection bits of the chosen entry |
| fill_en | input | 1 | Write one entry at the fill pointer |
| fill_vpn | input | 35 | Tag to write |
| fill_asn | input | 8 | Address-space number to write |
| fill_pfn | input | 31 | Frame field to write |
| fill_prot | input | 4 | Protection bits to write |
| inv_all | input | 1 | Invalidate every entry |
| inv_asn_en | input | 1 | Invalidate the entries of one address space |
| inv_asn | input | 8 | Address-space number to invalidate |

## Verification
A valid bit that is wrongly set or cleared shows up in the very next lookup of that entry's page and address-space number, as a flipped `hit`/`miss` pair. A fill pointer that slips shows up later: it becomes visible only once the wrap overwrites the wrong slot, up to ENTRIES fills after the fault. For that reason the bench fills past the wrap and then sweeps every resident translation. A wrong priority between duplicate matches shows up at once as a wrong frame on `pa`.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned DEF_VPN_W   = 35;
    localparam int unsigned DEF_OFF_W   = 13;
    localparam int unsigned DEF_ASN_W   = 8;
    localparam int unsigned DEF_PFN_W   = 31;
    localparam int unsigned DEF_PROT_W  = 4;
    localparam int unsigned DEF_ENTRIES = 128;

    // Write-side operation, decoded once per cycle in priority order
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_FILL,
        OP_FLUSH_ASN,
        OP_FILL_FLUSH_ASN,
        OP_FLUSH_ALL
    } tlb_op_e;
endpackage

// File: rtl/tlb_fill_ptr.sv
module tlb_fill_ptr #(
    parameter int unsigned N     = 128,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // R5: pointer steps by one and wraps after the last slot
    a_r5_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));
    // R7, R9: no advance without a fill
    a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int unsigned N      = 128,
    parameter int unsigned VPN_W  = 35,
    parameter int unsigned ASN_W  = 8,
    parameter int unsigned PFN_W  = 31,
    parameter int unsigned PROT_W = 4,
    parameter int unsigned IDX_W  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tlb_op_e           op,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASN_W-1:0]  wr_asn,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [PROT_W-1:0] wr_prot,
    input  logic [ASN_W-1:0]  flush_asn,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic [N-1:0]      match_vec,
    output logic [PFN_W-1:0]  pfn_arr  [N],
    output logic [PROT_W-1:0] prot_arr [N]
);
    logic [N-1:0]      vld_q, vld_d;
    logic [VPN_W-1:0]  tag_q [N];
    logic [ASN_W-1:0]  asn_q [N];
    logic              wr_en;

    assign wr_en = (op == OP_FILL) || (op == OP_FILL_FLUSH_ASN);

    always_comb begin
        vld_d = vld_q;
        unique case (op)
            OP_IDLE: ;
            OP_FILL: vld_d[wr_idx] = 1'b1;
            OP_FLUSH_ASN: begin
                for (int i = 0; i < N; i++)
                    if (asn_q[i] == flush_asn) vld_d[i] = 1'b0;
            end
            OP_FILL_FLUSH_ASN: begin
                for (int i = 0; i < N; i++)
                    if (asn_q[i] == flush_asn) vld_d[i] = 1'b0;
                vld_d[wr_idx] = 1'b1;
            end
            OP_FLUSH_ALL: vld_d = '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                tag_q[i]    <= wr_vpn;
                asn_q[i]    <= wr_asn;
                pfn_arr[i]  <= wr_pfn;
                prot_arr[i] <= wr_prot;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_vec[g] = vld_q[g] && (tag_q[g] == lk_vpn) && (asn_q[g] == lk_asn);

        // R8: a flush removes entries of that space, spares the others
        a_r8_flush_hits_owner: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_FLUSH_ASN && asn_q[g] == flush_asn) |=> !vld_q[g]);
        a_r8_flush_spares_others: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_FLUSH_ASN && vld_q[g] && asn_q[g] != flush_asn) |=> vld_q[g]);
    end

    // R7: one cycle empties the array
    a_r7_flush_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH_ALL) |=> (vld_q == '0));
    // R9: no write operation leaves every valid bit unchanged
    a_r9_idle_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> $stable(vld_q));
    // R5: the written slot is valid afterwards
    a_r5_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/tlb_prio_select.sv
module tlb_prio_select #(
    parameter int unsigned N      = 128,
    parameter int unsigned PFN_W  = 31,
    parameter int unsigned PROT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      match_vec,
    input  logic [PFN_W-1:0]  pfn_arr  [N],
    input  logic [PROT_W-1:0] prot_arr [N],
    output logic              hit,
    output logic [N-1:0]      grant,
    output logic [PFN_W-1:0]  pfn,
    output logic [PROT_W-1:0] prot
);
    // Scan from the top so the lowest matching index is the last to win
    always_comb begin
        grant = '0;
        pfn   = '0;
        prot  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                pfn      = pfn_arr[i];
                prot     = prot_arr[i];
            end
        end
    end

    assign hit = |grant;

    // R6: at most one winner, and no match sits below it
    a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r6_winner_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_vec & (grant - 1'b1)) == '0));
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned OFF_W   = DEF_OFF_W,
    parameter int unsigned ASN_W   = DEF_ASN_W,
    parameter int unsigned PFN_W   = DEF_PFN_W,
    parameter int unsigned PROT_W  = DEF_PROT_W,
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned PA_W   = PFN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [OFF_W-1:0]  lk_off,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              hit,
    output logic              miss,
    output logic [PA_W-1:0]   pa,
    output logic [PROT_W-1:0] prot,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASN_W-1:0]  fill_asn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              inv_all,
    input  logic              inv_asn_en,
    input  logic [ASN_W-1:0]  inv_asn
);
    tlb_op_e           op;
    logic [IDX_W-1:0]  ptr;
    logic [ENTRIES-1:0] match_vec, grant;
    logic [PFN_W-1:0]  pfn_arr  [ENTRIES];
    logic [PROT_W-1:0] prot_arr [ENTRIES];
    logic [PFN_W-1:0]  sel_pfn;

    always_comb begin
        if (inv_all)                   op = OP_FLUSH_ALL;
        else if (fill_en && inv_asn_en) op = OP_FILL_FLUSH_ASN;
        else if (fill_en)              op = OP_FILL;
        else if (inv_asn_en)           op = OP_FLUSH_ASN;
        else                           op = OP_IDLE;
    end

    tlb_fill_ptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .adv(fill_en && !inv_all), .ptr(ptr)
    );

    tlb_entry_array #(
        .N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W),
        .PFN_W(PFN_W), .PROT_W(PROT_W), .IDX_W(IDX_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .op(op), .wr_idx(ptr),
        .wr_vpn(fill_vpn), .wr_asn(fill_asn), .wr_pfn(fill_pfn), .wr_prot(fill_prot),
        .flush_asn(inv_asn), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .match_vec(match_vec), .pfn_arr(pfn_arr), .prot_arr(prot_arr)
    );

    tlb_prio_select #(.N(ENTRIES), .PFN_W(PFN_W), .PROT_W(PROT_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .match_vec(match_vec),
        .pfn_arr(pfn_arr), .prot_arr(prot_arr),
        .hit(hit), .grant(grant), .pfn(sel_pfn), .prot(prot)
    );

    assign miss = !hit;
    assign pa   = {sel_pfn, lk_off};

    // R2: hit and miss are never equal
    a_r2_hit_excl_miss: assert property (@(posedge clk) disable iff (!rst_n)
        hit ^ miss);
    // R2: a hit always has a matching entry behind it
    a_r2_hit_has_match: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (match_vec != '0));
endmodule

// File: tb/asn_tlb_bench.sv
module asn_tlb_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [34:0] lk_vpn = '0;
    logic [12:0] lk_off = '0;
    logic [7:0]  lk_asn = '0;
    logic        hit, miss;
    logic [43:0] pa;
    logic [3:0]  prot;
    logic        fill_en = 1'b0;
    logic [34:0] fill_vpn = '0;
    logic [7:0]  fill_asn = '0;
    logic [30:0] fill_pfn = '0;
    logic [3:0]  fill_prot = '0;
    logic        inv_all = 1'b0;
    logic        inv_asn_en = 1'b0;
    logic [7:0]  inv_asn = '0;

    int tests = 0;
    int fails = 0;

    // reference model built from the requirements
    bit          m_vld  [N];
    logic [34:0] m_vpn  [N];
    logic [7:0]  m_asn  [N];
    logic [30:0] m_pfn  [N];
    logic [3:0]  m_prot [N];
    int          m_ptr;

    always #10 clk = ~clk;

    asn_tlb #(.ENTRIES(N)) u_asn_tlb (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_off(lk_off), .lk_asn(lk_asn),
        .hit(hit), .miss(miss), .pa(pa), .prot(prot),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asn(fill_asn),
        .fill_pfn(fill_pfn), .fill_prot(fill_prot),
        .inv_all(inv_all), .inv_asn_en(inv_asn_en), .inv_asn(inv_asn)
    );

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // One write cycle; the model applies flushes first, then the fill
    task automatic wr_cycle(input bit f, input logic [34:0] v, input logic [7:0] a,
                            input logic [30:0] p, input logic [3:0] pr,
                            input bit ia, input bit ie, input logic [7:0] ea);
        fill_en = f; fill_vpn = v; fill_asn = a; fill_pfn = p; fill_prot = pr;
        inv_all = ia; inv_asn_en = ie; inv_asn = ea;
        @(posedge clk); #1;
        fill_en = 0; inv_all = 0; inv_asn_en = 0;
        if (ia) begin
            for (int i = 0; i < N; i++) m_vld[i] = 0;
        end else begin
            if (ie) for (int i = 0; i < N; i++) if (m_asn[i] == ea) m_vld[i] = 0;
            if (f) begin
                m_vld[m_ptr] = 1; m_vpn[m_ptr] = v; m_asn[m_ptr] = a;
                m_pfn[m_ptr] = p; m_prot[m_ptr] = pr;
                m_ptr = (m_ptr + 1) % N;
            end
        end
    endtask

    task automatic fill(input logic [34:0] v, input logic [7:0] a,
                        input logic [30:0] p, input logic [3:0] pr);
        wr_cycle(1, v, a, p, pr, 0, 0, '0);
    endtask

    task automatic look(input logic [34:0] v, input logic [7:0] a,
                        input logic [12:0] o, input string req);
        bit          eh = 0;
        logic [43:0] epa = '0;
        logic [3:0]  epr = '0;
        lk_vpn = v; lk_asn = a; lk_off = o;
        #2;
        for (int i = 0; i < N; i++) begin
            if (!eh && m_vld[i] && m_vpn[i] == v && m_asn[i] == a) begin
                eh = 1; epa = {m_pfn[i], o}; epr = m_prot[i];
            end
        end
        tests++;
        if (hit !== eh || miss !== !eh) begin
            fails++;
            $display("FAIL %s hit/miss vpn=%0h asn=%0h: got %b/%b exp %b/%b",
                     req, v, a, hit, miss, eh, !eh);
        end else if (eh && (pa !== epa || prot !== epr)) begin
            fails++;
            $display("FAIL %s pa/prot vpn=%0h asn=%0h: got %0h/%0h exp %0h/%0h",
                     req, v, a, pa, prot, epa, epr);
        end
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < N; i++) begin
            look(m_vpn[i], m_asn[i], 13'(i * 613 + 5), req);
            look(m_vpn[i], m_asn[i] ^ 8'h40, 13'h1fff, req);
            look(m_vpn[i] ^ 35'h4_0000_0000, m_asn[i], 13'h0, req);
        end
    endtask

    initial begin
        m_ptr = 0;
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_vpn[i] = 35'(i); m_asn[i] = 8'(i);
            m_pfn[i] = '0; m_prot[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: empty after reset
        for (int i = 0; i < 6; i++) look(35'(i * 3), 8'(i), 13'(i), "R1");

        // R2, R3: fill every slot and sweep
        for (int i = 0; i < N; i++)
            fill(35'(100 + i), 8'(i % 3), 31'(i * 7919 + 3), 4'(i + 1));
        sweep("R2");
        sweep("R3");

        // R5: wrap overwrites slot 0, old translation gone
        fill(35'(100), 8'd5, 31'h1234567, 4'ha);
        look(35'(100), 8'd0, 13'h11, "R5");
        look(35'(100), 8'd5, 13'h22, "R5");

        // R6: slot 1 gets (103,0) which slot 3 also holds; slot 1 must win
        fill(35'(103), 8'd0, 31'h7fff_0001, 4'h5);
        look(35'(103), 8'd0, 13'h0aa, "R6");

        // R4: slot 2 gets (104,4) while slot 4 keeps (104,1)
        fill(35'(104), 8'd4, 31'h0dead, 4'h3);
        look(35'(104), 8'd4, 13'h0bb, "R4");
        look(35'(104), 8'd1, 13'h0cc, "R4");
        look(35'(104), 8'd2, 13'h0dd, "R4");

        // R9: lookup storm, then everything unchanged
        for (int i = 0; i < 40; i++) begin
            lk_vpn = 35'(100 + i % 9); lk_asn = 8'(i % 6);
            @(posedge clk); #1;
        end
        sweep("R9");
        fill(35'(555), 8'd9, 31'h55, 4'h1); // lands in slot 3 if the pointer held
        look(35'(103), 8'd0, 13'h1, "R9");
        look(35'(555), 8'd9, 13'h2, "R9");

        // R8: flush address space 0, others stay
        wr_cycle(0, '0, '0, '0, '0, 0, 1, 8'd0);
        sweep("R8");
        // R8: fill with matching ASN during a flush of that ASN survives
        wr_cycle(1, 35'(200), 8'd1, 31'h200, 4'h7, 0, 1, 8'd1);
        look(35'(200), 8'd1, 13'h3, "R8");
        sweep("R8");

        // R7: flush all with a simultaneous fill: fill dropped, pointer held
        wr_cycle(1, 35'(300), 8'd3, 31'h300, 4'h2, 1, 0, '0);
        look(35'(300), 8'd3, 13'h4, "R7");
        sweep("R7");
        for (int i = 0; i < N; i++)
            fill(35'(400 + i), 8'(i), 31'(i * 131 + 9), 4'(i));
        sweep("R7");
        fill(35'(999), 8'd7, 31'h999, 4'hf);
        sweep("R5");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule